// File: doc/BRIEF.md
# Dual-Issue Structural Hazard Scheduler

This block is the issue controller of a small in-order core that can issue two instructions per cycle. Each cycle it sees the two oldest decoded instructions in program order. Slot 0 holds the older one and slot 1 the younger. Each carries an operation class, a destination register with a write enable, and two source registers. The block decides which of the two may leave that cycle and names the execution resource each one goes to.

The execution resources are:
- two simple units, one of which alone can run certain condition-register and vector operations;
- a branch unit that does not use an issue slot;
- one load/store unit;
- a pipelined multiply unit that accepts one operation per cycle;
- a non-pipelined divider.

Some simple-unit operations stay for two or three cycles. While they stay, they keep their unit and one issue slot.

A register scoreboard keeps one countdown per register, loaded from the latency of the class that writes it. The block only decides. The instruction source upstream holds back every instruction that was not granted and presents it again on the next cycle. When slot 0 issues and slot 1 does not, the instruction from slot 1 moves into slot 0.

Top module: `dual_issue_sched`

## Requirements

Class codes on `s*_class`:
- 0: plain simple operation
- 1: operation restricted to the second simple unit
- 2: two-cycle simple operation
- 3: three-cycle simple operation
- 4: control-flow operation
- 5: multiply-unit operation
- 6: short divide
- 7: long divide
- 8: memory access

Unit codes on `s*_unit`:
- 0: none
- 1: simple unit A
- 2: simple unit B
- 3: branch unit
- 4: load/store unit
- 5: multiply unit

- R1: While `rst` is high, no grant is given. A synchronous reset clears the divider counter, the multi-cycle hold and every scoreboard countdown, so after reset a divide that reads any register issues at once.
- R2: With all resources free, code 0 goes to unit 1, code 1 to unit 2, codes 2 and 3 to unit 1, code 4 to unit 3, codes 5 to 7 to unit 5 and code 8 to unit 4. Two instructions granted in the same cycle never name the same unit. A younger code 0, 2 or 3 takes unit 1 when unit 1 is free, and otherwise unit 2.
- R3: Issue is in order. Slot 1 is granted only when slot 0 is granted in the same cycle. `s*_stall` is high for a valid instruction that was not granted.
- R4: A younger code 1 never issues in the same cycle as an older code 0, 2 or 3. An older code 1 with a younger code 0 may issue together. Two code-1 instructions never issue together.
- R5: The multiply unit accepts at most one of codes 5 to 7 per cycle. A consumer of a code 5 result may issue 4 cycles after its producer.
- R6: A code 6 divide keeps the divider for 14 cycles and a code 7 divide for 29 cycles. A later divide issues no earlier than that many cycles after the first. A code 5 operation may issue while the divider is busy.
- R7: At most one code 8 instruction issues per cycle. Its consumer may issue 3 cycles after it.
- R8: A code 4 instruction uses no issue slot, so it may issue beside another instruction even while a multi-cycle operation holds a slot. Two code 4 instructions never issue in the same cycle.
- R9: A code 2 or code 3 instruction holds its simple unit and one issue slot for 1 or 2 further cycles. In those cycles:
  - only one instruction that is not code 4 may issue;
  - the held unit is unavailable;
  - another code 2 or code 3 instruction stalls.
- R10: A consumer stalls while a countdown for one of its sources or its destination is nonzero. Results have these latencies: 1 cycle for codes 0, 1 and 4, 2 for code 2, 3 for code 3, and the latencies in R5 to R7 for the other codes. Slot 1 also stalls when it reads or writes the register that slot 0 writes in the same cycle.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s0_valid | input | 1 | Older slot holds an instruction |
| s0_class | input | 4 | Older slot class code |
| s0_dst | input | IDX_W | Older slot destination register |
| s0_dst_we | input | 1 | Older slot writes its destination |
| s0_src_a | input | IDX_W | Older slot first source |
| s0_src_b | input | IDX_W | Older slot second source |
| s1_valid | input | 1 | Younger slot holds an instruction |
| s1_class | input | 4 | Younger slot class code |
| s1_dst | input | IDX_W | Younger slot destination register |
| s1_dst_we | input | 1 | Younger slot writes its destination |
| s1_src_a | input | IDX_W | Younger slot first source |
| s1_src_b | input | IDX_W | Younger slot second source |
| s0_issue | output | 1 | Older slot granted |
| s1_issue | output | 1 | Younger slot granted |
| s0_unit | output | 3 | Unit given to the older slot |
| s1_unit | output | 3 | Unit given to the younger slot |
| s0_stall | output | 1 | Older slot valid but held |
| s1_stall | output | 1 | Younger slot valid but held |

## Verification

Two kinds of conflict can meet in one cycle: a structural conflict between the two slots, and a conflict with state left by earlier cycles. One source of earlier state is a multi-cycle hold, with its unit and issue slot, that is still active when a new pair arrives. Another is a divider that is still busy while a multiply-unit operation asks for stage 0.

The bench sweeps every pair of the nine classes from an idle state and compares both grants and units with values worked out from the class rules. Directed sequences then lay new pairs over active holds and busy divider windows. They count the exact cycle in which a held-back instruction leaves and compare it with the latency or occupancy of the class that produced the conflict.

// File: rtl/sched_pkg.sv
package sched_pkg;

   typedef enum logic [3:0] {
      OP_ALU    = 4'd0,
      OP_ALU_HI = 4'd1,
      OP_SEQ2   = 4'd2,
      OP_SEQ3   = 4'd3,
      OP_CTRL   = 4'd4,
      OP_MUL    = 4'd5,
      OP_DIV    = 4'd6,
      OP_FDIV   = 4'd7,
      OP_MEM    = 4'd8
   } op_class_e;

   typedef enum logic [2:0] {
      UNIT_NONE = 3'd0,
      UNIT_SU_A = 3'd1,
      UNIT_SU_B = 3'd2,
      UNIT_BR   = 3'd3,
      UNIT_LSU  = 3'd4,
      UNIT_MU   = 3'd5
   } unit_e;

   function automatic logic is_seq(op_class_e c);
      return (c == OP_SEQ2) || (c == OP_SEQ3);
   endfunction

   function automatic logic is_divide(op_class_e c);
      return (c == OP_DIV) || (c == OP_FDIV);
   endfunction

   // classes that may sit on either simple unit (take unit A first)
   function automatic logic flex_simple(op_class_e c);
      return (c == OP_ALU) || is_seq(c);
   endfunction

endpackage

// File: rtl/sched_scoreboard.sv
module sched_scoreboard
   import sched_pkg::*;
#(
   parameter int NUM_REGS = 32,
   parameter int CNT_W    = 5,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr0_en,
   input  logic [IDX_W-1:0] wr0_idx,
   input  logic [CNT_W-1:0] wr0_cnt,
   input  logic             wr1_en,
   input  logic [IDX_W-1:0] wr1_idx,
   input  logic [CNT_W-1:0] wr1_cnt,
   input  logic [IDX_W-1:0] q0_a,
   input  logic [IDX_W-1:0] q0_b,
   input  logic [IDX_W-1:0] q0_d,
   input  logic             q0_d_en,
   input  logic [IDX_W-1:0] q1_a,
   input  logic [IDX_W-1:0] q1_b,
   input  logic [IDX_W-1:0] q1_d,
   input  logic             q1_d_en,
   output logic             busy0,
   output logic             busy1
);

   logic [NUM_REGS-1:0] pend;

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk) begin
         if (rst)
            cnt_q <= '0;
         else if (wr0_en && wr0_idx == IDX_W'(g))
            cnt_q <= wr0_cnt;
         else if (wr1_en && wr1_idx == IDX_W'(g))
            cnt_q <= wr1_cnt;
         else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
      end
      assign pend[g] = (cnt_q != '0);
   end

   assign busy0 = pend[q0_a] | pend[q0_b] | (q0_d_en & pend[q0_d]);
   assign busy1 = pend[q1_a] | pend[q1_b] | (q1_d_en & pend[q1_d]);

   // R10
   no_dual_write_chk: assert property (@(posedge clk) disable iff (rst)
      !(wr0_en && wr1_en && wr0_idx == wr1_idx));

endmodule

// File: rtl/sched_unit_tracker.sv
module sched_unit_tracker
   import sched_pkg::*;
#(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             div_start,
   input  logic [CNT_W-1:0] div_len,
   input  logic             seq_start,
   input  logic [1:0]       seq_len,
   input  logic             seq_on_b,
   output logic             div_busy,
   output logic             hold_active,
   output logic             hold_on_b
);

   logic [CNT_W-1:0] div_cnt_q;
   logic [1:0]       hold_cnt_q;
   logic             hold_b_q;

   always_ff @(posedge clk) begin
      if (rst)
         div_cnt_q <= '0;
      else if (div_start)
         div_cnt_q <= div_len;
      else if (div_cnt_q != '0)
         div_cnt_q <= div_cnt_q - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         hold_cnt_q <= '0;
         hold_b_q   <= 1'b0;
      end else if (seq_start) begin
         hold_cnt_q <= seq_len;
         hold_b_q   <= seq_on_b;
      end else if (hold_cnt_q != '0) begin
         hold_cnt_q <= hold_cnt_q - 1'b1;
      end
   end

   assign div_busy    = (div_cnt_q != '0);
   assign hold_active = (hold_cnt_q != '0);
   assign hold_on_b   = hold_b_q;

   // R6
   div_idle_start_chk: assert property (@(posedge clk) disable iff (rst)
      div_start |-> (div_cnt_q == '0));

   // R9
   hold_drain_chk: assert property (@(posedge clk) disable iff (rst)
      (hold_cnt_q != '0) |=> (hold_cnt_q == $past(hold_cnt_q) - 2'd1));

endmodule

// File: rtl/sched_slot_arbiter.sv
module sched_slot_arbiter
   import sched_pkg::*;
(
   input  logic      vld0,
   input  logic      vld1,
   input  op_class_e cls0,
   input  op_class_e cls1,
   input  logic      haz0,
   input  logic      haz1,
   input  logic      dep01,
   input  logic      div_busy,
   input  logic      hold_active,
   input  logic      hold_on_b,
   output logic      go0,
   output logic      go1,
   output unit_e     unit0,
   output unit_e     unit1
);

   logic  su_a_free, su_b_free, su_a_left, su_b_left, slot_ok1;
   unit_e cand0, cand1;

   assign su_a_free = !(hold_active && !hold_on_b);
   assign su_b_free = !(hold_active &&  hold_on_b);

   always_comb begin
      cand0 = UNIT_NONE;
      unique case (cls0)
         OP_ALU:    cand0 = su_a_free ? UNIT_SU_A : (su_b_free ? UNIT_SU_B : UNIT_NONE);
         OP_ALU_HI: cand0 = su_b_free ? UNIT_SU_B : UNIT_NONE;
         OP_SEQ2,
         OP_SEQ3:   cand0 = hold_active ? UNIT_NONE : UNIT_SU_A;
         OP_CTRL:   cand0 = UNIT_BR;
         OP_MUL:    cand0 = UNIT_MU;
         OP_DIV,
         OP_FDIV:   cand0 = div_busy ? UNIT_NONE : UNIT_MU;
         OP_MEM:    cand0 = UNIT_LSU;
         default:   cand0 = UNIT_NONE;
      endcase
   end

   assign go0       = vld0 && !haz0 && (cand0 != UNIT_NONE);
   assign su_a_left = su_a_free && !(go0 && cand0 == UNIT_SU_A);
   assign su_b_left = su_b_free && !(go0 && cand0 == UNIT_SU_B);
   // one issue slot is spent by a held multi-cycle op; control flow uses none
   assign slot_ok1  = (cls1 == OP_CTRL) || !(hold_active && cand0 != UNIT_BR);

   always_comb begin
      cand1 = UNIT_NONE;
      unique case (cls1)
         OP_ALU:    cand1 = su_a_left ? UNIT_SU_A : (su_b_left ? UNIT_SU_B : UNIT_NONE);
         OP_ALU_HI: cand1 = (su_b_left && !flex_simple(cls0)) ? UNIT_SU_B : UNIT_NONE;
         OP_SEQ2,
         OP_SEQ3:   cand1 = (hold_active || is_seq(cls0)) ? UNIT_NONE :
                            (su_a_left ? UNIT_SU_A : (su_b_left ? UNIT_SU_B : UNIT_NONE));
         OP_CTRL:   cand1 = (cand0 == UNIT_BR) ? UNIT_NONE : UNIT_BR;
         OP_MUL:    cand1 = (cand0 == UNIT_MU) ? UNIT_NONE : UNIT_MU;
         OP_DIV,
         OP_FDIV:   cand1 = (cand0 == UNIT_MU || div_busy) ? UNIT_NONE : UNIT_MU;
         OP_MEM:    cand1 = (cand0 == UNIT_LSU) ? UNIT_NONE : UNIT_LSU;
         default:   cand1 = UNIT_NONE;
      endcase
   end

   assign go1   = go0 && vld1 && !haz1 && !dep01 && slot_ok1 && (cand1 != UNIT_NONE);
   assign unit0 = go0 ? cand0 : UNIT_NONE;
   assign unit1 = go1 ? cand1 : UNIT_NONE;

endmodule

// File: rtl/dual_issue_sched.sv
module dual_issue_sched
   import sched_pkg::*;
#(
   parameter int  NUM_REGS  = 32,
   parameter int  MUL_LAT   = 4,
   parameter int  MEM_LAT   = 3,
   parameter int  DIV_OCC   = 14,
   parameter int  FDIV_OCC  = 29,
   localparam int IDX_W     = $clog2(NUM_REGS),
   localparam int MAX_OCC   = (FDIV_OCC > DIV_OCC) ? FDIV_OCC : DIV_OCC,
   localparam int CNT_W     = $clog2(MAX_OCC)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             s0_valid,
   input  logic [3:0]       s0_class,
   input  logic [IDX_W-1:0] s0_dst,
   input  logic             s0_dst_we,
   input  logic [IDX_W-1:0] s0_src_a,
   input  logic [IDX_W-1:0] s0_src_b,
   input  logic             s1_valid,
   input  logic [3:0]       s1_class,
   input  logic [IDX_W-1:0] s1_dst,
   input  logic             s1_dst_we,
   input  logic [IDX_W-1:0] s1_src_a,
   input  logic [IDX_W-1:0] s1_src_b,
   output logic             s0_issue,
   output logic             s1_issue,
   output logic [2:0]       s0_unit,
   output logic [2:0]       s1_unit,
   output logic             s0_stall,
   output logic             s1_stall
);

   if (NUM_REGS < 2 || (1 << IDX_W) != NUM_REGS) begin : g_bad_regs
      $error("NUM_REGS must be a power of two of at least 2");
   end
   if (MAX_OCC < 4 || MUL_LAT > MAX_OCC || MEM_LAT > MAX_OCC ||
       MUL_LAT < 1 || MEM_LAT < 1 || DIV_OCC < 2 || FDIV_OCC < 2) begin : g_bad_lat
      $error("latencies must be at least 1 and divider occupancies bound all latencies");
   end

   op_class_e cls0, cls1;
   logic      haz0, haz1, dep01, div_busy, hold_active, hold_on_b;
   logic      arb_go0, arb_go1, div_start, seq_start, seq_on_b;
   logic [CNT_W-1:0] div_len;
   logic [1:0]       seq_len;
   unit_e     arb_u0, arb_u1;

   assign cls0 = op_class_e'(s0_class);
   assign cls1 = op_class_e'(s1_class);

   // countdown loaded on issue: latency minus one, so a consumer leaves L cycles later
   function automatic logic [CNT_W-1:0] wait_of(op_class_e c);
      case (c)
         OP_SEQ2: return CNT_W'(1);
         OP_SEQ3: return CNT_W'(2);
         OP_MUL:  return CNT_W'(MUL_LAT - 1);
         OP_DIV:  return CNT_W'(DIV_OCC - 1);
         OP_FDIV: return CNT_W'(FDIV_OCC - 1);
         OP_MEM:  return CNT_W'(MEM_LAT - 1);
         default: return '0;
      endcase
   endfunction

   assign dep01 = s0_dst_we && (s1_src_a == s0_dst || s1_src_b == s0_dst ||
                                (s1_dst_we && s1_dst == s0_dst));

   sched_scoreboard #(.NUM_REGS(NUM_REGS), .CNT_W(CNT_W)) u_sb (
      .clk(clk), .rst(rst),
      .wr0_en(s0_issue && s0_dst_we), .wr0_idx(s0_dst), .wr0_cnt(wait_of(cls0)),
      .wr1_en(s1_issue && s1_dst_we), .wr1_idx(s1_dst), .wr1_cnt(wait_of(cls1)),
      .q0_a(s0_src_a), .q0_b(s0_src_b), .q0_d(s0_dst), .q0_d_en(s0_dst_we),
      .q1_a(s1_src_a), .q1_b(s1_src_b), .q1_d(s1_dst), .q1_d_en(s1_dst_we),
      .busy0(haz0), .busy1(haz1));

   sched_slot_arbiter u_arb (
      .vld0(s0_valid), .vld1(s1_valid), .cls0(cls0), .cls1(cls1),
      .haz0(haz0), .haz1(haz1), .dep01(dep01), .div_busy(div_busy),
      .hold_active(hold_active), .hold_on_b(hold_on_b),
      .go0(arb_go0), .go1(arb_go1), .unit0(arb_u0), .unit1(arb_u1));

   assign s0_issue = arb_go0 && !rst;
   assign s1_issue = arb_go1 && !rst;
   assign s0_unit  = s0_issue ? arb_u0 : UNIT_NONE;
   assign s1_unit  = s1_issue ? arb_u1 : UNIT_NONE;
   assign s0_stall = s0_valid && !s0_issue;
   assign s1_stall = s1_valid && !s1_issue;

   always_comb begin
      div_start = 1'b0;
      div_len   = '0;
      seq_start = 1'b0;
      seq_len   = 2'd0;
      seq_on_b  = 1'b0;
      if (s0_issue && is_divide(cls0)) begin
         div_start = 1'b1;
         div_len   = wait_of(cls0);
      end else if (s1_issue && is_divide(cls1)) begin
         div_start = 1'b1;
         div_len   = wait_of(cls1);
      end
      if (s0_issue && is_seq(cls0)) begin
         seq_start = 1'b1;
         seq_len   = (cls0 == OP_SEQ3) ? 2'd2 : 2'd1;
         seq_on_b  = (arb_u0 == UNIT_SU_B);
      end else if (s1_issue && is_seq(cls1)) begin
         seq_start = 1'b1;
         seq_len   = (cls1 == OP_SEQ3) ? 2'd2 : 2'd1;
         seq_on_b  = (arb_u1 == UNIT_SU_B);
      end
   end

   sched_unit_tracker #(.CNT_W(CNT_W)) u_trk (
      .clk(clk), .rst(rst),
      .div_start(div_start), .div_len(div_len),
      .seq_start(seq_start), .seq_len(seq_len), .seq_on_b(seq_on_b),
      .div_busy(div_busy), .hold_active(hold_active), .hold_on_b(hold_on_b));

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      rst |-> (!s0_issue && !s1_issue));

   // R3
   in_order_chk: assert property (@(posedge clk) disable iff (rst)
      s1_issue |-> s0_issue);

   // R2
   unit_distinct_chk: assert property (@(posedge clk) disable iff (rst)
      (s0_issue && s1_issue) |-> (s0_unit != s1_unit));

   // R4
   su_b_pair_chk: assert property (@(posedge clk) disable iff (rst)
      (s1_issue && cls1 == OP_ALU_HI) |-> !flex_simple(cls0));

   // R6
   div_gap_chk: assert property (@(posedge clk) disable iff (rst)
      div_start |=> !div_start);

endmodule

// File: tb/dual_issue_sched_tb.sv
module dual_issue_sched_tb;

   localparam int NREG = 32;
   localparam int IW   = 5;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          v0 = 0, w0 = 0, v1 = 0, w1 = 0;
   logic [3:0]    c0 = 0, c1 = 0;
   logic [IW-1:0] d0 = 0, a0 = 0, b0 = 0, d1 = 0, a1 = 0, b1 = 0;
   logic          i0, i1, st0, st1;
   logic [2:0]    u0, u1;

   int n_chk = 0;
   int n_err = 0;

   always #10 clk = ~clk;

   dual_issue_sched #(.NUM_REGS(NREG)) u_dut (
      .clk(clk), .rst(rst),
      .s0_valid(v0), .s0_class(c0), .s0_dst(d0), .s0_dst_we(w0), .s0_src_a(a0), .s0_src_b(b0),
      .s1_valid(v1), .s1_class(c1), .s1_dst(d1), .s1_dst_we(w1), .s1_src_a(a1), .s1_src_b(b1),
      .s0_issue(i0), .s1_issue(i1), .s0_unit(u0), .s1_unit(u1),
      .s0_stall(st0), .s1_stall(st1));

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic put0(input logic v, input int c, input int d, input logic we,
                       input int sa, input int sb);
      v0 = v; c0 = 4'(c); d0 = IW'(d); w0 = we; a0 = IW'(sa); b0 = IW'(sb);
   endtask

   task automatic put1(input logic v, input int c, input int d, input logic we,
                       input int sa, input int sb);
      v1 = v; c1 = 4'(c); d1 = IW'(d); w1 = we; a1 = IW'(sa); b1 = IW'(sb);
   endtask

   // wait for the driving point, then let inputs settle before sampling
   task automatic cyc_drive();
      @(negedge clk);
   endtask

   task automatic settle();
      #5;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      put0(0, 0, 0, 0, 0, 0);
      put1(0, 0, 0, 0, 0, 0);
      @(negedge clk);
      rst = 1'b0;
   endtask

   function automatic int lat_of(input int c);
      case (c)
         2: return 2;
         3: return 3;
         5: return 4;
         6: return 14;
         7: return 29;
         8: return 3;
         default: return 1;
      endcase
   endfunction

   function automatic int exp_unit0(input int c);
      case (c)
         0, 2, 3: return 1;
         1: return 2;
         4: return 3;
         5, 6, 7: return 5;
         8: return 4;
         default: return 0;
      endcase
   endfunction

   function automatic int exp_unit1(input int ca, input int cb);
      bit a_taken = (ca == 0 || ca == 2 || ca == 3);
      case (cb)
         0: return a_taken ? 2 : 1;
         1: return (ca <= 3) ? 0 : 2;
         2, 3: return (ca == 2 || ca == 3) ? 0 : (a_taken ? 2 : 1);
         4: return (ca == 4) ? 0 : 3;
         5, 6, 7: return (ca >= 5 && ca <= 7) ? 0 : 5;
         8: return (ca == 8) ? 0 : 4;
         default: return 0;
      endcase
   endfunction

   // issue producer of class pc writing r7, then a plain consumer reading r7; returns stall count
   task automatic measure_wait(input int pc, output int stalls);
      stalls = 0;
      do_reset();
      put0(1, pc, 7, 1, 1, 2);
      put1(0, 0, 0, 0, 0, 0);
      settle();
      check("R10 producer issues", int'(i0), 1);
      for (int k = 0; k < 60; k++) begin
         cyc_drive();
         put0(1, 0, 9, 1, 7, 3);
         settle();
         if (i0) break;
         stalls++;
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin : main
      int s;
      // R1: no grant while reset is high
      put0(1, 0, 1, 1, 2, 3);
      put1(1, 0, 4, 1, 5, 6);
      @(negedge clk);
      settle();
      check("R1 grant0 during reset", int'(i0), 0);
      check("R1 grant1 during reset", int'(i1), 0);

      // R2/R4/R5/R7/R8: every class pair from idle
      for (int ca = 0; ca < 9; ca++) begin
         for (int cb = 0; cb < 9; cb++) begin
            do_reset();
            put0(1, ca, 1, 1, 2, 3);
            put1(1, cb, 4, 1, 5, 6);
            settle();
            check($sformatf("R2 unit0 pair %0d/%0d", ca, cb), int'(u0), exp_unit0(ca));
            check($sformatf("R4 R5 R7 R8 unit1 pair %0d/%0d", ca, cb), int'(u1), exp_unit1(ca, cb));
            check($sformatf("R3 stall1 pair %0d/%0d", ca, cb), int'(st1),
                  (exp_unit1(ca, cb) == 0) ? 1 : 0);
         end
      end

      // R10 / R5 / R7: latency per class
      for (int pc = 0; pc < 9; pc++) begin
         if (pc == 1 || pc == 4) continue;
         measure_wait(pc, s);
         check($sformatf("R10 wait after class %0d", pc), s, lat_of(pc) - 1);
      end

      // R1: reset clears scoreboard and divider
      do_reset();
      put0(1, 7, 7, 1, 1, 2);
      settle();
      check("R1 long divide issues", int'(i0), 1);
      do_reset();
      put0(1, 6, 8, 1, 7, 7);
      settle();
      check("R1 divide after reset", int'(i0), 1);

      // R6: divider occupancy, multiply overlaps
      for (int dc = 6; dc <= 7; dc++) begin
         do_reset();
         put0(1, dc, 10, 0, 1, 2);
         settle();
         check("R6 first divide", int'(i0), 1);
         cyc_drive();
         put0(1, 5, 11, 0, 1, 2);
         settle();
         check("R6 multiply while divider busy", int'(i0), 1);
         s = 0;
         for (int k = 0; k < 60; k++) begin
            cyc_drive();
            put0(1, 6, 12, 0, 1, 2);
            settle();
            if (i0) break;
            s++;
         end
         check($sformatf("R6 divide gap class %0d", dc), s, ((dc == 6) ? 14 : 29) - 2);
      end

      // R9 / R8: three-cycle hold on unit 1
      do_reset();
      put0(1, 3, 20, 0, 1, 2);
      settle();
      check("R9 three-cycle op unit", int'(u0), 1);
      cyc_drive();
      put0(1, 0, 21, 0, 1, 2);
      put1(1, 0, 22, 0, 1, 2);
      settle();
      check("R9 held unit avoided", int'(u0), 2);
      check("R9 one slot during hold", int'(i1), 0);
      cyc_drive();
      put0(1, 0, 22, 0, 1, 2);
      put1(1, 4, 23, 0, 1, 2);
      settle();
      check("R8 control beside held op", int'(u1), 3);
      check("R9 plain op second hold cycle", int'(u0), 2);
      cyc_drive();
      put0(1, 0, 24, 0, 1, 2);
      put1(1, 0, 25, 0, 1, 2);
      settle();
      check("R9 hold released", int'(i1), 1);

      // R9: second multi-cycle op waits
      do_reset();
      put0(1, 2, 20, 0, 1, 2);
      settle();
      cyc_drive();
      put0(1, 2, 21, 0, 1, 2);
      settle();
      check("R9 second two-cycle op stalls", int'(st0), 1);
      cyc_drive();
      settle();
      check("R9 second two-cycle op issues", int'(i0), 1);

      // R9 / R4: hold on unit 2 blocks restricted op
      do_reset();
      put0(1, 0, 20, 0, 1, 2);
      put1(1, 2, 21, 0, 1, 2);
      settle();
      check("R9 younger two-cycle on unit 2", int'(u1), 2);
      cyc_drive();
      put0(1, 1, 22, 0, 1, 2);
      put1(0, 0, 0, 0, 0, 0);
      settle();
      check("R4 restricted op waits on held unit", int'(i0), 0);
      cyc_drive();
      settle();
      check("R4 restricted op after hold", int'(u0), 2);

      // R10: same-cycle dependence, write-after-write, no write enable
      do_reset();
      put0(1, 0, 3, 1, 1, 2);
      put1(1, 0, 5, 1, 3, 4);
      settle();
      check("R10 slot1 reads slot0 dst", int'(i1), 0);
      do_reset();
      put0(1, 0, 3, 1, 1, 2);
      put1(1, 0, 3, 1, 4, 5);
      settle();
      check("R10 slot1 writes slot0 dst", int'(i1), 0);
      do_reset();
      put0(1, 0, 3, 0, 1, 2);
      put1(1, 0, 5, 1, 3, 4);
      settle();
      check("R10 no write enable no hazard", int'(i1), 1);

      // R3: stalled older blocks younger; empty older blocks younger
      do_reset();
      put0(1, 5, 7, 1, 1, 2);
      settle();
      cyc_drive();
      put0(1, 0, 9, 1, 7, 1);
      put1(1, 0, 10, 1, 2, 3);
      settle();
      check("R3 older stalls", int'(st0), 1);
      check("R3 younger held behind older", int'(i1), 0);
      do_reset();
      put0(0, 0, 1, 0, 2, 3);
      put1(1, 0, 4, 0, 5, 6);
      settle();
      check("R3 younger without older", int'(i1), 0);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule